// File: doc/BRIEF.md
# Byte-Programmed PWM Generator with Auto-Off

A single-channel pulse-width modulator configured through a write-only, byte-wide register port made of an address, a data byte and a write strobe. The period and the high time are 16-bit counts of a fixed time base. The time base runs at 8 MHz, so one tick is 125 ns. Each 16-bit value is loaded as two bytes. The upper byte is held in a staging register and has no effect on the output. The full value takes effect on the cycle its lower byte is written. This lets software rewrite a setting without the output seeing half of a new value.

A separate enable register starts and stops generation. A 16-bit auto-off countdown can clear the enable after a programmed number of milliseconds, so a stalled host cannot leave the output driven forever. The value 0xFFFF turns the countdown off. Polarity is fixed: every period starts with the high portion. The block sits behind whatever serial bridge delivers the byte writes. Parameters set the number of clocks per time-base tick and the number of ticks per millisecond step.

Top module: `bpwm_top`

## Requirements
- R1: After reset the output is low, enable is 0, period and high time are 0, every staging byte is 0, and the auto-off value is 0xFFFF.
- R2: A write to an upper-byte address changes only a staging byte. Period is committed by a write to 0xA4 with the staged upper byte from 0xA5. High time is committed by a write to 0xA6 with the staged byte from 0xA7. Auto-off is committed by a write to 0xA2 with the staged byte from 0xA1.
- R3: A write to 0xA3 sets enable from data bit 0. While enable is 0 the output is low and the period counter is held at 0, so each start begins a fresh period.
- R4: While enabled, the counter advances once per tick through 0 to period-1 and then wraps to 0. The output is high while the counter is below the high time and low otherwise.
- R5: A high time greater than or equal to a non-zero period gives a constant high output.
- R6: A high time of 0, or a period of 0, gives a constant low output.
- R7: Committing a new period or high time does not reset the counter. The new values are compared with the running count at once. A counter at or beyond period-1 wraps to 0 on its next tick.
- R8: While enabled with an auto-off value N other than 0xFFFF, one countdown step is taken every MS_TICKS ticks. Enable clears on the Nth step after the commit, and N=0 behaves as N=1. A write of 1 to 0xA3 on the same cycle wins over the expiry.
- R9: An auto-off value of 0xFFFF never clears enable.
- R10: Each commit of the auto-off value reloads the countdown and restarts the millisecond step counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register data byte |
| pwm_o | output | 1 | Modulated output, high portion first |

## Verification
The bench checks several corner cases, each chosen to expose a specific design fault:
- A staged upper byte of the high time is left pending for many periods. A design that committed it early would switch to constant high too soon.
- The period is enlarged in mid-period. A design that restarted its counter would rise right after the commit instead of finishing the stretched low phase.
- Zero high time and zero period are each tested. A design that mishandled them would leak pulses.
- Auto-off is probed for the exact cycle of expiry. It is also probed for a reload that must postpone expiry, and for the 0xFFFF code, which is also the reset value. A design with a wrong reset value would turn off after one millisecond.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned VAL_W  = 16;

    localparam logic [VAL_W-1:0] AO_NEVER = 16'hFFFF;

    // Register addresses seen by software.
    typedef enum logic [BYTE_W-1:0] {
        A_AO_HI   = 8'hA1,
        A_AO_LO   = 8'hA2,
        A_EN      = 8'hA3,
        A_PER_LO  = 8'hA4,
        A_PER_HI  = 8'hA5,
        A_DUTY_LO = 8'hA6,
        A_DUTY_HI = 8'hA7
    } reg_addr_e;

    // Committed configuration driving the datapath.
    typedef struct packed {
        logic [VAL_W-1:0] period;
        logic [VAL_W-1:0] duty;
        logic [VAL_W-1:0] ao_val;
        logic             enable;
    } cfg_t;

    // Staged upper bytes.
    typedef struct packed {
        logic [BYTE_W-1:0] per_hi;
        logic [BYTE_W-1:0] duty_hi;
        logic [BYTE_W-1:0] ao_hi;
    } stage_t;

    function automatic logic level_high(input logic [VAL_W-1:0] cnt,
                                        input logic [VAL_W-1:0] per,
                                        input logic [VAL_W-1:0] duty);
        if (per == '0 || duty == '0)
            return 1'b0;
        if (duty >= per)
            return 1'b1;
        return cnt < duty;
    endfunction

endpackage

// File: rtl/bpwm_tick.sv
module bpwm_tick #(
    parameter int unsigned TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst || pc == LAST)
            pc <= '0;
        else
            pc <= pc + 1'b1;
    end

    assign tick_o = (pc == LAST);

endmodule

// File: rtl/bpwm_regfile.sv
module bpwm_regfile
    import bpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              expire_i,
    output cfg_t              cfg_o,
    output logic              ao_load_o,
    output logic [VAL_W-1:0]  ao_load_val_o
);
    stage_t stage;
    logic   en_write;

    assign en_write      = wr_en && (wr_addr == A_EN);
    assign ao_load_o     = wr_en && (wr_addr == A_AO_LO);
    assign ao_load_val_o = {stage.ao_hi, wr_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage        <= '0;
            cfg_o.period <= '0;
            cfg_o.duty   <= '0;
            cfg_o.ao_val <= AO_NEVER;
            cfg_o.enable <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_AO_HI:   stage.ao_hi   <= wr_data;
                    A_AO_LO:   cfg_o.ao_val  <= {stage.ao_hi, wr_data};
                    A_EN:      cfg_o.enable  <= wr_data[0];
                    A_PER_LO:  cfg_o.period  <= {stage.per_hi, wr_data};
                    A_PER_HI:  stage.per_hi  <= wr_data;
                    A_DUTY_LO: cfg_o.duty    <= {stage.duty_hi, wr_data};
                    A_DUTY_HI: stage.duty_hi <= wr_data;
                    default: ;
                endcase
            end
            if (expire_i && !en_write)
                cfg_o.enable <= 1'b0;
        end
    end

    p_per_stage_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_PER_HI) |=> $stable(cfg_o.period));

    p_duty_stage_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_DUTY_HI) |=> $stable(cfg_o.duty));

endmodule

// File: rtl/bpwm_wave.sv
module bpwm_wave
    import bpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             enable,
    input  logic [VAL_W-1:0] period,
    input  logic [VAL_W-1:0] duty,
    output logic             pwm_o
);
    logic [VAL_W-1:0] cnt;
    logic             wrap;

    assign wrap = (period == '0) || (cnt >= period - 16'd1);

    always_ff @(posedge clk) begin
        if (rst || !enable)
            cnt <= '0;
        else if (tick)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

    assign pwm_o = enable && level_high(cnt, period, duty);

    p_hold_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!enable && !pwm_o) |=> (!enable || cnt == '0));

endmodule

// File: rtl/bpwm_autooff.sv
module bpwm_autooff
    import bpwm_pkg::*;
#(
    parameter int unsigned MS_TICKS = 8000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             enable,
    input  logic [VAL_W-1:0] ao_val,
    input  logic             load,
    input  logic [VAL_W-1:0] load_val,
    output logic             expire_o
);
    localparam int unsigned MW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
    localparam logic [MW-1:0] MS_LAST = MW'(MS_TICKS - 1);

    logic [MW-1:0]    ms;
    logic [VAL_W-1:0] cd;
    logic             active, step;

    assign active = enable && (ao_val != AO_NEVER);
    assign step   = active && tick && (ms == MS_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ms <= '0;
            cd <= '0;
        end else if (load) begin
            ms <= '0;
            cd <= load_val;
        end else if (!active) begin
            ms <= '0;
        end else if (tick) begin
            if (ms == MS_LAST) begin
                ms <= '0;
                cd <= (cd <= 16'd1) ? '0 : cd - 1'b1;
            end else begin
                ms <= ms + 1'b1;
            end
        end
    end

    assign expire_o = step && !load && (cd <= 16'd1);

    p_cd_monotonic_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cd <= $past(cd)));

endmodule

// File: rtl/bpwm_top.sv
module bpwm_top
    import bpwm_pkg::*;
#(
    parameter int unsigned TICK_DIV = 1,
    parameter int unsigned MS_TICKS = 8000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       pwm_o
);
    cfg_t             cfg;
    logic             tick, expire, ao_load;
    logic [VAL_W-1:0] ao_load_val;

    bpwm_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    bpwm_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .expire_i(expire), .cfg_o(cfg),
        .ao_load_o(ao_load), .ao_load_val_o(ao_load_val)
    );

    bpwm_wave u_wave (
        .clk(clk), .rst(rst), .tick(tick), .enable(cfg.enable),
        .period(cfg.period), .duty(cfg.duty), .pwm_o(pwm_o)
    );

    bpwm_autooff #(.MS_TICKS(MS_TICKS)) u_ao (
        .clk(clk), .rst(rst), .tick(tick), .enable(cfg.enable),
        .ao_val(cfg.ao_val), .load(ao_load), .load_val(ao_load_val),
        .expire_o(expire)
    );

    p_expire_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (expire && !(wr_en && wr_addr == A_EN)) |=> !cfg.enable);

    p_never_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg.enable && cfg.ao_val == AO_NEVER && !wr_en) |=> cfg.enable);

    p_off_output_low_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_EN && !wr_data[0]) |=> !pwm_o);

endmodule

// File: tb/bpwm_top_tb_top.sv
module bpwm_top_tb_top;
    import bpwm_pkg::*;

    localparam int MS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] data = '0;
    logic       pwm_o;

    bpwm_top #(.TICK_DIV(1), .MS_TICKS(MS)) dut_i (
        .clk(clk), .rst(rst), .wr_en(we), .wr_addr(addr),
        .wr_data(data), .pwm_o(pwm_o)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    when;
        logic  val;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t item;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: sample between edges, compare against queued expectations.
    always @(posedge clk) begin
        #2;
        while (q.size() > 0 && q[0].when <= cyc) begin
            item = q.pop_front();
            checks++;
            if (item.when < cyc || pwm_o !== item.val) begin
                errors++;
                $display("FAIL %s cyc %0d: pwm_o=%b expected %b",
                         item.tag, item.when, pwm_o, item.val);
            end
        end
    end

    task automatic push(input int when, input logic v, input string tag);
        exp_t e;
        e.when = when; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    // Expected level from R4/R5/R6 given the cycle where the counter was 0.
    task automatic expect_pat(input int e0, input int per, input int duty,
                              input int from, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            int   t = from + i;
            logic v;
            if (per == 0 || duty == 0) v = 1'b0;
            else if (duty >= per)      v = 1'b1;
            else                       v = (((t - e0) % per) < duty);
            push(t, v, tag);
        end
    endtask

    task automatic expect_low(input int from, input int n, input string tag);
        for (int i = 0; i < n; i++) push(from + i, 1'b0, tag);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    // Called at a negedge; the write commits at the next posedge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; data = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic direct(input logic v, input string tag);
        checks++;
        if (pwm_o !== v) begin
            errors++;
            $display("FAIL %s: pwm_o=%b expected %b", tag, pwm_o, v);
        end
    endtask

    initial begin
        int e0, c, w, w2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        direct(1'b0, "R1 reset output");

        // R4 basic waveform, period 10, high time 3
        wr(A_PER_HI, 8'd0); wr(A_PER_LO, 8'd10);
        wr(A_DUTY_HI, 8'd0); wr(A_DUTY_LO, 8'd3);
        direct(1'b0, "R3 configured but disabled");
        wr(A_EN, 8'd1); e0 = cyc;
        // R1/R9: reset auto-off is 0xFFFF, so no expiry over 4 ms
        expect_pat(e0, 10, 3, e0 + 1, 45, "R4 R1 basic and never by reset");
        drain();

        // R2 staged upper byte has no effect
        wr(A_DUTY_HI, 8'd1); c = cyc;
        expect_pat(e0, 10, 3, c + 1, 20, "R2 staged high byte");
        drain();
        // R5 commit gives duty 0x100 >= period
        wr(A_DUTY_LO, 8'd0); c = cyc;
        expect_pat(e0, 10, 256, c + 1, 20, "R5 full high");
        drain();

        // R6 zero high time
        wr(A_DUTY_HI, 8'd0); wr(A_DUTY_LO, 8'd0); c = cyc;
        expect_low(c + 1, 25, "R6 zero duty");
        drain();

        // R7 period grows mid-cycle without counter reset
        wr(A_DUTY_LO, 8'd4); c = cyc;
        expect_pat(e0, 10, 4, c + 1, 12, "R4 duty 4");
        drain();
        while (((cyc + 1 - e0) % 10) != 5) @(negedge clk);
        wr(A_PER_LO, 8'd20); c = cyc;
        for (int t = c + 1; t <= c + 25; t++)
            push(t, (((5 + t - c) % 20) < 4), "R7 no counter reset");
        drain();

        // R3 disable forces low
        wr(A_EN, 8'd0); c = cyc;
        expect_low(c + 1, 20, "R3 disable");
        drain();

        // R6 zero period
        wr(A_PER_LO, 8'd0); wr(A_DUTY_LO, 8'd5); wr(A_EN, 8'd1); c = cyc;
        expect_low(c + 1, 20, "R6 zero period");
        drain();

        // R8 auto-off after 3 steps of MS ticks
        wr(A_PER_LO, 8'd4); e0 = cyc;
        wr(A_DUTY_LO, 8'd2);
        wr(A_AO_HI, 8'd0); wr(A_AO_LO, 8'd3); w = cyc;
        expect_pat(e0, 4, 2, w + 1, 3 * MS - 1, "R8 before expiry");
        expect_low(w + 3 * MS, 15, "R8 after expiry");
        drain();

        // R10 reload postpones expiry
        wr(A_EN, 8'd1); e0 = cyc;
        wr(A_AO_LO, 8'd3); w = cyc;
        expect_pat(e0, 4, 2, w + 1, 14, "R10 first window");
        while (cyc != w + 14) @(negedge clk);
        wr(A_AO_LO, 8'd3); w2 = cyc;
        expect_pat(e0, 4, 2, w2 + 1, 3 * MS - 1, "R10 reload postpones");
        expect_low(w2 + 3 * MS, 10, "R10 expiry after reload");
        drain();

        // R9 explicit never code
        wr(A_AO_HI, 8'hFF); wr(A_AO_LO, 8'hFF);
        wr(A_EN, 8'd1); e0 = cyc;
        expect_pat(e0, 4, 2, e0 + 1, 60, "R9 never");
        drain();

        // R1 reset mid-run clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        direct(1'b0, "R1 after reset");
        wr(A_EN, 8'd1); c = cyc;
        expect_low(c + 1, 10, "R1 period and duty cleared");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule